// File: doc/BRIEF.md
# Three-Class Priority Bus Arbiter

This block decides which of several requesting functions may drive a shared, asynchronous bus next. Six active-low request lines arrive from outside the clock domain: one for peripheral direct transfers, four interrupt levels, and one for the CPU's own direct transfers. Each line passes through a synchronizer. A fixed priority encoder then picks one winner. The winner receives a one-hot grant, which opens its select phase. The grant then holds for the whole service phase, until the owner pulses `done`.

While an owner is in service, the arbiter keeps choosing a registered "next" winner from the other pending requests. It re-evaluates that choice on every cycle, so a request with higher priority that arrives late can still displace a weaker one. When `done` arrives, the next winner becomes the owner on the same clock edge, and the bus sees no idle cycle between the two owners. The current owner is never a candidate for the next grant. If no other request is pending, the bus goes idle with every grant low.

Top module: `bus_arbiter`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, every bit of `grant` is 0.
- R2: At most one bit of `grant` is high in any cycle. The bit positions are: bit 5 = peripheral direct transfer, bit 4 = interrupt level 4, bit 3 = level 3, bit 2 = level 2, bit 1 = level 1, bit 0 = CPU.
- R3: The peripheral direct-transfer request beats every other request. While it is pending, no interrupt or CPU request is granted.
- R4: Among the interrupt lines, a higher level beats a lower one. `req_int_n[3]` is level 4 (the highest) and `req_int_n[0]` is level 1 (the lowest).
- R5: The CPU request is granted only when no other request is pending.
- R6: With the bus idle, a request that is low before a rising edge raises its grant bit on the third rising edge, counting that edge as the first. Two edges go to the synchronizer and one to the grant register.
- R7: While a grant is held and `done` is low, `grant` does not change. When `done` is sampled high and a next winner is pending, the grant moves to that winner on the same edge, with no idle cycle.
- R8: The next winner is re-chosen on every cycle of service. A request with higher priority that arrives during service wins over one that was already waiting.
- R9: When `done` is sampled high and nothing else is pending, `grant` becomes all zero. With no requests at all, `grant` stays all zero.
- R10: A `done` pulse while the bus is idle has no effect on `grant`.
- R11: The current owner is not a candidate for the next grant. An owner that keeps its request low gives way to any other pending request when it signals `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_ddt_n | input | 1 | Peripheral direct-transfer request, active low, asynchronous |
| req_int_n | input | NUM_INT | Interrupt requests, active low; the MSB is the highest level |
| req_cpu_n | input | 1 | CPU direct-transfer request, active low, asynchronous |
| done | input | 1 | The current owner has finished its service phase |
| grant | output | NUM_INT+2 | One-hot grant: DDT, interrupt levels from high to low, CPU |

## Verification
The checker tests on every cycle that the grant is one-hot or empty. It also checks that the grant is frozen while an owner is in service without `done`, that an idle bus with a synchronized peripheral request grants that request, and that an idle bus with nothing pending stays idle. Only the bench scenarios can show the following:
- the three-edge latency through the synchronizer;
- the full descending chain of owners;
- a late request with higher priority overtaking a waiting one;
- an owner that keeps requesting giving way to another request;
- a stray `done` on an idle bus being harmless.

// File: rtl/bus_arbiter.sv
module bus_arbiter #(
  parameter int NUM_INT     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int NG         = NUM_INT + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_ddt_n,
  input  logic [NUM_INT-1:0] req_int_n,
  input  logic               req_cpu_n,
  input  logic               done,
  output logic [NG-1:0]      grant
);

  logic [NG-1:0] raw_req;
  logic [NG-1:0] sync_q [SYNC_STAGES];
  logic [NG-1:0] req, cand, pick;
  logic [NG-1:0] grant_q, next_q;
  logic          busy;

  assign raw_req = ~{req_ddt_n, req_int_n, req_cpu_n};

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= raw_req;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) sync_q[s] <= '0;
      else        sync_q[s] <= sync_q[s-1];
    end
  end

  assign req  = sync_q[SYNC_STAGES-1];
  assign cand = req & ~grant_q;
  assign busy = |grant_q;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NG; i++) begin
      if (cand[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= '0;
      next_q  <= '0;
    end else if (!busy) begin
      grant_q <= pick;
      next_q  <= '0;
    end else if (done) begin
      grant_q <= next_q;
      next_q  <= '0;
    end else begin
      next_q  <= pick;
    end
  end

  assign grant = grant_q;

endmodule

// File: rtl/bus_arbiter_chk.sv
module bus_arbiter_chk #(
  parameter int NUM_INT = 4,
  localparam int NG     = NUM_INT + 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic [NG-1:0] req,
  input logic [NG-1:0] grant
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> grant == '0);

  assert_onehot_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_ddt_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && req[NG-1]) |=> grant[NG-1]);

  assert_hold_in_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && !done) |=> grant == $past(grant));

  assert_stay_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant == '0 && req == '0) |=> grant == '0);

endmodule

bind bus_arbiter bus_arbiter_chk #(.NUM_INT(NUM_INT)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .req(req), .grant(grant)
);

// File: tb/bus_arbiter_tb.sv
module bus_arbiter_tb;
  localparam int NI = 4;
  localparam int NG = NI + 2;
  localparam logic [NG-1:0] G_DDT = 6'b100000, G_I4 = 6'b010000, G_I3 = 6'b001000,
                            G_I2 = 6'b000100, G_I1 = 6'b000010, G_CPU = 6'b000001;

  logic clk = 0, rst_n = 0, req_ddt_n = 1, req_cpu_n = 1, done = 0;
  logic [NI-1:0] req_int_n = '1;
  logic [NG-1:0] grant;

  typedef struct { logic [NG-1:0] g; string tag; } item_t;
  item_t sb[$];
  item_t it;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bus_arbiter #(.NUM_INT(NI)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_ddt_n(req_ddt_n), .req_int_n(req_int_n),
    .req_cpu_n(req_cpu_n), .done(done), .grant(grant)
  );

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      it = sb.pop_front();
      checks++;
      if (grant !== it.g) begin
        errors++;
        $display("FAIL %s: grant=%b expected=%b", it.tag, grant, it.g);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_g(logic [NG-1:0] g, string tag);
    item_t x;
    x.g = g; x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic pulse_done();
    done = 1;
    cyc(1);
    done = 0;
  endtask

  initial begin
    cyc(1);
    expect_g('0, "R1 in reset");
    cyc(2);
    rst_n = 1;
    cyc(1);
    expect_g('0, "R1 after reset");
    cyc(4);
    expect_g('0, "R9 idle no requests");

    req_cpu_n = 0;
    cyc(2);
    expect_g('0, "R6 not yet after two edges");
    cyc(1);
    expect_g(G_CPU, "R6 R5 cpu alone granted on third edge");
    req_cpu_n = 1;
    cyc(3);
    expect_g(G_CPU, "R7 held without done");
    pulse_done();
    expect_g('0, "R9 done with nothing pending");
    cyc(3);

    req_ddt_n = 0; req_int_n = '0; req_cpu_n = 0;
    cyc(3);
    expect_g(G_DDT, "R3 ddt beats all");
    req_ddt_n = 1;
    cyc(3);
    expect_g(G_DDT, "R7 ddt held");
    pulse_done();
    expect_g(G_I4, "R4 R7 level4 next without gap");
    req_int_n[3] = 1; cyc(3); pulse_done();
    expect_g(G_I3, "R4 level3");
    req_int_n[2] = 1; cyc(3); pulse_done();
    expect_g(G_I2, "R4 level2");
    req_int_n[1] = 1; cyc(3); pulse_done();
    expect_g(G_I1, "R4 level1");
    req_int_n[0] = 1; cyc(3); pulse_done();
    expect_g(G_CPU, "R5 cpu last");
    req_cpu_n = 1; cyc(3); pulse_done();
    expect_g('0, "R9 chain ends idle");
    cyc(3);

    req_int_n[1] = 0; req_int_n[2] = 0;
    cyc(3);
    expect_g(G_I3, "R4 level3 over level2");
    req_int_n = '1; cyc(3); pulse_done();
    expect_g('0, "R9 idle after level3");
    cyc(3);

    req_cpu_n = 0;
    cyc(3);
    expect_g(G_CPU, "R5 cpu owner");
    req_int_n[0] = 0;
    cyc(3);
    req_ddt_n = 0;
    cyc(3);
    expect_g(G_CPU, "R7 owner kept while others wait");
    pulse_done();
    expect_g(G_DDT, "R8 R3 late ddt overtakes waiting level1");
    req_ddt_n = 1; cyc(3); pulse_done();
    expect_g(G_I1, "R8 level1 after ddt");
    req_int_n[0] = 1; cyc(3); pulse_done();
    expect_g(G_CPU, "R5 cpu regains");
    req_cpu_n = 1; cyc(3); pulse_done();
    expect_g('0, "R9 idle again");
    cyc(3);

    req_ddt_n = 0;
    cyc(3);
    expect_g(G_DDT, "R6 ddt from idle");
    req_int_n[1] = 0;
    cyc(3);
    pulse_done();
    expect_g(G_I2, "R11 owner still requesting gives way");
    cyc(1);
    pulse_done();
    expect_g(G_DDT, "R11 previous owner returns");
    req_ddt_n = 1; req_int_n = '1;
    cyc(3); pulse_done();
    expect_g('0, "R9 all released");
    cyc(3);

    pulse_done();
    expect_g('0, "R10 done while idle");
    cyc(3);
    expect_g('0, "R10 still idle");
    cyc(2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule